// File: doc/BRIEF.md
# Unaligned Access Packet Sequencer

This block turns one memory access request into the ordered series of 32-bit bus packets needed to carry it. A request gives a byte start address, a two-bit size code and a one-cycle start strobe. The block works out from the size and the low address bits how many bus packets the access spans. It then presents them one at a time: the word-aligned packet address, a two-bit position tag (first, middle or last), the byte offset of the access within its first word, and a valid strobe.

The memory side accepts each packet by raising an acknowledge input. A packet stays on the outputs, unchanged, until the acknowledge is seen on a rising clock edge. The block then moves to the next packet or returns to idle. A one-cycle done pulse accompanies the acknowledge of the final packet. A downstream aligner uses the tag and offset to steer bytes and build byte enables. That steering is not part of this block.

The controller has four named states. IDLE waits for a start. SEND_FIRST presents packet tag 00. SEND_MID presents tag 01. SEND_LAST presents tag 10. The transitions are:
- IDLE to SEND_FIRST when a start is accepted.
- SEND_FIRST to IDLE on acknowledge when the access needs one packet.
- SEND_FIRST to SEND_LAST on acknowledge when it needs two packets.
- SEND_FIRST to SEND_MID on acknowledge when it needs three packets.
- SEND_MID to SEND_LAST on acknowledge.
- SEND_LAST to IDLE on acknowledge.
- Every other state and input combination holds the current state.

Top module: `pkt_sequencer`

## Requirements
- R1: Size code 00 (byte) always produces exactly one packet, tagged 00, whatever the start offset.
- R2: Size code 01 (word) produces one packet tagged 00 for offsets 0, 1 and 2. For offset 3 it produces two packets, tagged 00 then 10.
- R3: Size code 10 (dword) produces one packet tagged 00 when the offset is 0. Any nonzero offset produces two packets, tagged 00 then 10.
- R4: Size code 11 (qword) produces two packets tagged 00 then 10 when the offset is 0. Any nonzero offset produces three packets, tagged 00, 01, 10.
- R5: The first packet address is the request address with bits [1:0] cleared. Each following packet's address is the previous one plus 4.
- R6: The offset output equals request address bits [1:0] on every packet of the access.
- R7: While valid is high and acknowledge is low at a rising edge, address, tag and offset keep their values in the next cycle and valid stays high.
- R8: Done is high only in a cycle where valid and acknowledge are both high and the last packet of the access is on the outputs. Valid is low in the following cycle.
- R9: A start strobe while a sequence is in progress is ignored. The running sequence continues unchanged and no further sequence follows it.
- R10: A synchronous active-high reset returns the block to idle with valid and done low. This holds even in the middle of a sequence.
- R11: The first packet is valid in the cycle after the edge that accepts the start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Start strobe for a new access, taken only when idle |
| req_addr | input | ADDR_W | Byte start address of the access |
| req_size | input | 2 | Size code: 00 byte, 01 word, 10 dword, 11 qword |
| pkt_ack | input | 1 | Memory side accepts the presented packet |
| pkt_valid | output | 1 | A packet is presented |
| pkt_addr | output | ADDR_W | Word-aligned packet address |
| pkt_tag | output | 2 | Packet position: 00 first, 01 middle, 10 last |
| pkt_offset | output | 2 | Start byte offset of the access |
| seq_done | output | 1 | Pulse with the acknowledge of the final packet |

## Verification
The hardest situation to reach is a fresh start strobe arriving while a three-packet qword is part way through. It is made worse when the memory side stalls, because the captured offset and the address stepping must then survive both the stall and the competing request. The stimulus starts an unaligned qword and holds acknowledge low for several cycles on the first packet. During that stall it drives a start with a different address and size. It then lets the sequence finish and confirms that the tags, addresses and offset follow the original request, and that no new packet appears afterwards. A second scenario raises reset while a middle packet is presented to show that the sequence is abandoned cleanly.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_QWORD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        IDLE       = 2'b00,
        SEND_FIRST = 2'b01,
        SEND_MID   = 2'b10,
        SEND_LAST  = 2'b11
    } seq_state_e;

    localparam logic [1:0] TAG_FIRST = 2'b00;
    localparam logic [1:0] TAG_MID   = 2'b01;
    localparam logic [1:0] TAG_LAST  = 2'b10;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/pkt_count_plan.sv
module pkt_count_plan
    import pkt_seq_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic [1:0] start_off,
    output logic [1:0] pkt_total
);

    always_comb begin
        unique case (acc_size_e'(size_code))
            SZ_BYTE:  pkt_total = 2'd1;
            SZ_WORD:  pkt_total = (start_off == 2'd3) ? 2'd2 : 2'd1;
            SZ_DWORD: pkt_total = (start_off != 2'd0) ? 2'd2 : 2'd1;
            SZ_QWORD: pkt_total = (start_off != 2'd0) ? 2'd3 : 2'd2;
            default:  pkt_total = 2'd1;
        endcase
    end

    always_comb begin
        assert_total_in_range_R4: assert (pkt_total != 2'd0);
    end

endmodule

// File: rtl/pkt_addr_track.sv
module pkt_addr_track
    import pkt_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= {load_addr[ADDR_W-1:2], 2'b00};
        end else if (step) begin
            cur_addr <= cur_addr + STRIDE;
        end
    end

    assert_step_adds_four_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cur_addr == $past(cur_addr) + STRIDE));

    assert_load_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_addr[1:0] == 2'b00));

endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
    import pkt_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              pkt_ack,
    output logic              pkt_valid,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [1:0]        pkt_tag,
    output logic [1:0]        pkt_offset,
    output logic              seq_done
);

    seq_state_e state_q, state_d;
    logic [1:0] plan_total;
    logic [1:0] total_q;
    logic [1:0] off_q;
    logic       accept;
    logic       step_addr;

    pkt_count_plan u_plan (
        .size_code (req_size),
        .start_off (req_addr[1:0]),
        .pkt_total (plan_total)
    );

    assign accept    = (state_q == IDLE) && req_start;
    assign step_addr = (state_q != IDLE) && pkt_ack && (state_d != IDLE);

    pkt_addr_track #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_addr (req_addr),
        .step      (step_addr),
        .cur_addr  (pkt_addr)
    );

    // Request capture: the offset and the packet count are held for the whole sequence.
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= 2'b00;
            total_q <= 2'd1;
        end else if (accept) begin
            off_q   <= req_addr[1:0];
            total_q <= plan_total;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE: begin
                if (req_start) state_d = SEND_FIRST;
            end
            SEND_FIRST: begin
                if (pkt_ack) begin
                    if (total_q == 2'd1)      state_d = IDLE;
                    else if (total_q == 2'd2) state_d = SEND_LAST;
                    else                      state_d = SEND_MID;
                end
            end
            SEND_MID: begin
                if (pkt_ack) state_d = SEND_LAST;
            end
            SEND_LAST: begin
                if (pkt_ack) state_d = IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pkt_valid  = 1'b0;
        pkt_tag    = TAG_FIRST;
        seq_done   = 1'b0;
        pkt_offset = off_q;
        unique case (state_q)
            IDLE: begin
                pkt_valid = 1'b0;
            end
            SEND_FIRST: begin
                pkt_valid = 1'b1;
                pkt_tag   = TAG_FIRST;
                seq_done  = pkt_ack && (total_q == 2'd1);
            end
            SEND_MID: begin
                pkt_valid = 1'b1;
                pkt_tag   = TAG_MID;
            end
            SEND_LAST: begin
                pkt_valid = 1'b1;
                pkt_tag   = TAG_LAST;
                seq_done  = pkt_ack;
            end
        endcase
    end

    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ack) |=> (pkt_valid && $stable(pkt_addr) && $stable(pkt_tag) && $stable(pkt_offset)));

    assert_done_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (pkt_valid && pkt_ack));

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !pkt_valid);

    assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_addr[1:0] == 2'b00));

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ack && !seq_done) |=> (pkt_valid && $stable(pkt_offset)));

    assert_mid_then_last_R4: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ack && pkt_tag == TAG_MID) |=> (pkt_valid && pkt_tag == TAG_LAST));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && req_start && !pkt_ack) |=> $stable(pkt_offset));

    assert_first_after_start_R11: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && req_start) |=> (pkt_valid && pkt_tag == TAG_FIRST));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!pkt_valid && !seq_done));

endmodule

// File: tb/pkt_sequencer_bench.sv
module pkt_sequencer_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_start;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic          pkt_ack;
    logic          pkt_valid;
    logic [AW-1:0] pkt_addr;
    logic [1:0]    pkt_tag;
    logic [1:0]    pkt_offset;
    logic          seq_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pkt_sequencer #(.ADDR_W(AW)) u_pkt_sequencer (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_size(req_size), .pkt_ack(pkt_ack), .pkt_valid(pkt_valid),
        .pkt_addr(pkt_addr), .pkt_tag(pkt_tag), .pkt_offset(pkt_offset),
        .seq_done(seq_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b00:   return 1;
            2'b01:   return (off == 2'd3) ? 2 : 1;
            2'b10:   return (off != 2'd0) ? 2 : 1;
            default: return (off != 2'd0) ? 3 : 2;
        endcase
    endfunction

    // One full access with a stall of 'stall' cycles on each packet.
    // With 'poke' set, a competing start is driven during the first stall (R9).
    task automatic run_access(input string req, input logic [AW-1:0] a, input logic [1:0] sz,
                              input int stall, input bit poke);
        int n = exp_count(sz, a[1:0]);
        logic [AW-1:0] base = {a[AW-1:2], 2'b00};
        @(negedge clk);
        req_addr = a; req_size = sz; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        req_addr = ~a; req_size = ~sz;
        check({req, " R11 valid after start"}, 64'(pkt_valid), 64'd1);
        for (int i = 0; i < n; i++) begin
            logic [1:0] et = (i == 0) ? 2'b00 : ((i == n - 1) ? 2'b10 : 2'b01);
            for (int s = 0; s < stall; s++) begin
                if (poke && i == 0) begin
                    req_start = 1'b1; req_addr = a + 32'h101; req_size = sz ^ 2'b01;
                end
                #1;
                check({req, " R7 no done while stalled"}, 64'(seq_done), 64'd0);
                @(negedge clk);
                req_start = 1'b0;
                check({req, " R7 valid held"}, 64'(pkt_valid), 64'd1);
            end
            check({req, " tag"}, 64'(pkt_tag), 64'(et));
            check({req, " R5 addr"}, 64'(pkt_addr), 64'(base + AW'(4 * i)));
            check({req, " R6 offset"}, 64'(pkt_offset), 64'(a[1:0]));
            pkt_ack = 1'b1;
            #1;
            check({req, " R8 done"}, 64'(seq_done), 64'(i == n - 1));
            @(negedge clk);
            pkt_ack = 1'b0;
        end
        check({req, " R8 idle after last"}, 64'(pkt_valid), 64'd0);
        @(negedge clk);
        check({req, " R9 no extra sequence"}, 64'(pkt_valid), 64'd0);
    endtask

    task automatic t_reset();
        check("R10 valid after reset", 64'(pkt_valid), 64'd0);
        check("R10 done after reset", 64'(seq_done), 64'd0);
    endtask

    task automatic t_bytes();
        for (int o = 0; o < 4; o++) run_access("R1 byte", 32'h1000 + o, 2'b00, 0, 0);
    endtask

    task automatic t_words();
        for (int o = 0; o < 4; o++) run_access("R2 word", 32'h2200 + o, 2'b01, 1, 0);
    endtask

    task automatic t_dwords();
        for (int o = 0; o < 4; o++) run_access("R3 dword", 32'h3300 + o, 2'b10, 0, 0);
    endtask

    task automatic t_qwords();
        for (int o = 0; o < 4; o++) run_access("R4 qword", 32'hFFFF_FFF0 + o, 2'b11, 2, 0);
    endtask

    task automatic t_busy_start();
        run_access("R9 busy start", 32'h4443, 2'b11, 3, 1);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        req_addr = 32'h5551; req_size = 2'b11; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0; pkt_ack = 1'b1;
        @(negedge clk);
        pkt_ack = 1'b0;
        check("R4 middle tag before reset", 64'(pkt_tag), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 valid after mid reset", 64'(pkt_valid), 64'd0);
        check("R10 done after mid reset", 64'(seq_done), 64'd0);
        run_access("R10 access after reset", 32'h6602, 2'b10, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_start = 1'b0; req_addr = '0; req_size = 2'b00; pkt_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bytes();
        t_words();
        t_dwords();
        t_qwords();
        t_busy_start();
        t_mid_reset();
        finish_run();
    end

endmodule